// File: doc/BRIEF.md
# Periodic Branch Outcome Replayer

This block predicts conditional branches whose outcomes follow a fixed periodic sequence that is known when the design is elaborated. It does not learn. It keeps a phase counter modulo the sequence length. The counter moves forward by one on every clock edge where the fetch or decode logic marks the current instruction as a conditional branch. A small lookup turns the current phase into a taken or not-taken bit.

The prediction is a combinational function of the phase. It is valid during the whole cycle in which the branch strobe is high, so the consumer reads it in that cycle and the edge that ends the cycle moves the phase on to the next sequence element. The block has no input for the actual outcome. If the branch stream follows the built-in sequence, every prediction is right. If the stream is the exact inverse of that sequence, every prediction is wrong.

Top module: `replay_predictor`

## Requirements
- R1: While the reset is asserted, and in the first cycle after the reset is released, the phase is 0 and the output equals pattern element 0 (bit 0 of `PAT_BITS`). This also applies when the reset is asserted in the middle of a sequence.
- R2: On each rising clock edge where `br_strobe_i` is 1 and the phase is below `PAT_LEN-1`, the phase increases by exactly one.
- R3: On a rising clock edge where `br_strobe_i` is 0, the phase holds its value, so the output does not change.
- R4: When the phase is `PAT_LEN-1`, a strobed edge returns the phase to 0, so the output sequence repeats with period `PAT_LEN`.
- R5: The output `pred_taken_o` is 1 for taken and 0 for not taken. It equals bit k of `PAT_BITS`, where k is the number of strobed edges since reset, taken modulo `PAT_LEN`. This holds for any mix of strobed and idle cycles.
- R6: With the default settings (`PAT_LEN`=4, `PAT_BITS`=8'b0000_1011), the sequence taken, taken, not-taken, taken is replayed. Against a branch stream that repeats this sequence from reset, every prediction is correct.
- R7: Against a branch stream that is the bitwise complement of the built-in sequence, every prediction is wrong, which gives 0% accuracy.
- R8: With `PAT_LEN`=5 and `PAT_BITS`=8'b0000_0111, the block replays taken, taken, taken, not-taken, not-taken, and every prediction against that repeating stream is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Reset, active low. Assertion is asynchronous; release must be synchronous to `clk_i` |
| br_strobe_i | input | 1 | 1 when the instruction in this cycle is a conditional branch; the phase advances at the end of the cycle |
| pred_taken_o | output | 1 | Prediction for the branch in this cycle: 1 = taken, 0 = not taken |

## Verification
The bench runs two instances side by side: the period-4 default and a period-5 instance. This shows that the wrap point follows `PAT_LEN` and is not a power of two fixed in the logic. The stimulus includes runs of idle cycles with no strobe, which separate holding from advancing. It includes unbroken strobe bursts that cross the wrap point several times, which separate a correct wrap from an off-by-one. It includes a stream scored against the complemented sequence, which must give zero correct predictions, and a reset in the middle of a sequence, which must restart at element 0. Random strobe densities then check that the output always follows the count of strobed edges modulo the period and is unaffected by idle cycles.

// File: rtl/replay_predictor_pkg.sv
package replay_predictor_pkg;

  // Largest sequence the lookup is sized to hold
  localparam int unsigned MAX_LEN = 8;

  // Width of a counter that must hold the values 0 .. len-1
  function automatic int unsigned phase_width(int unsigned len);
    int unsigned w;
    w = 1;
    while ((1 << w) < len) w++;
    return w;
  endfunction

endpackage

// File: rtl/replay_phase_ctr.sv
module replay_phase_ctr #(
  parameter int unsigned LEN = 4,
  parameter int unsigned PW  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [PW-1:0] phase_o
);

  localparam logic [PW-1:0] LAST = PW'(LEN - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          phase_en;

  // Next-state: wrap at the last element, otherwise step by one
  always_comb begin
    phase_en = step_i;
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/replay_pattern_lut.sv
module replay_pattern_lut #(
  parameter int unsigned LEN  = 4,
  parameter int unsigned PW   = 2,
  parameter logic [7:0]  BITS = 8'b0000_1011
) (
  input  logic [PW-1:0] phase_i,
  output logic          taken_o
);

  localparam int unsigned SLOTS = 1 << PW;

  logic [SLOTS-1:0] table_w;

  // Slots past the sequence length are unreachable; they are tied to 0
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < LEN) begin : g_used
      assign table_w[g] = BITS[g];
    end else begin : g_pad
      assign table_w[g] = 1'b0;
    end
  end

  assign taken_o = table_w[phase_i];

endmodule

// File: rtl/replay_predictor.sv
module replay_predictor #(
  parameter int unsigned PAT_LEN  = 4,
  parameter logic [7:0]  PAT_BITS = 8'b0000_1011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic br_strobe_i,
  output logic pred_taken_o
);

  import replay_predictor_pkg::*;

  localparam int unsigned PW = phase_width(PAT_LEN);

  logic [PW-1:0] phase_q;

  replay_phase_ctr #(
    .LEN (PAT_LEN),
    .PW  (PW)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (br_strobe_i),
    .phase_o (phase_q)
  );

  replay_pattern_lut #(
    .LEN  (PAT_LEN),
    .PW   (PW),
    .BITS (PAT_BITS)
  ) u_lut (
    .phase_i (phase_q),
    .taken_o (pred_taken_o)
  );

endmodule

// File: rtl/replay_predictor_chk.sv
module replay_predictor_chk #(
  parameter int unsigned PAT_LEN  = 4,
  parameter logic [7:0]  PAT_BITS = 8'b0000_1011,
  parameter int unsigned PW       = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          br_strobe_i,
  input logic          pred_taken_o,
  input logic [PW-1:0] phase_i
);

  localparam logic [PW-1:0] LAST = PW'(PAT_LEN - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_strobe_i |=> $stable(phase_i) && $stable(pred_taken_o)); // R3

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_strobe_i && phase_i != LAST) |=> phase_i == $past(phase_i) + ONE); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_strobe_i && phase_i == LAST) |=> phase_i == '0); // R4

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i <= LAST); // R4

  AST_OUT_FROM_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o == PAT_BITS[phase_i]); // R5

  AST_RESET_START: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_i == '0) && (pred_taken_o == PAT_BITS[0])); // R1

endmodule

bind replay_predictor replay_predictor_chk #(
  .PAT_LEN  (PAT_LEN),
  .PAT_BITS (PAT_BITS),
  .PW       (PW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .br_strobe_i  (br_strobe_i),
  .pred_taken_o (pred_taken_o),
  .phase_i      (phase_q)
);

// File: tb/sim_replay_predictor.sv
module sim_replay_predictor;

  localparam int unsigned LEN_A = 4;
  localparam logic [7:0]  PAT_A = 8'b0000_1011; // T,T,NT,T
  localparam int unsigned LEN_B = 5;
  localparam logic [7:0]  PAT_B = 8'b0000_0111; // T,T,T,NT,NT

  logic clk = 1'b0;
  logic rst_n;
  logic strobe;
  logic pred_a;
  logic pred_b;

  always #5 clk = ~clk;

  replay_predictor #(.PAT_LEN(LEN_A), .PAT_BITS(PAT_A)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .br_strobe_i(strobe), .pred_taken_o(pred_a));

  replay_predictor #(.PAT_LEN(LEN_B), .PAT_BITS(PAT_B)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .br_strobe_i(strobe), .pred_taken_o(pred_b));

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  int unsigned ph_a   = 0;
  int unsigned ph_b   = 0;
  bit          done   = 0;

  function automatic logic exp_bit(logic [7:0] pat, int unsigned ph);
    return pat[ph];
  endfunction

  function automatic int unsigned next_ph(int unsigned ph, int unsigned len);
    return (ph + 1 == len) ? 0 : ph + 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check both outputs mid-cycle, then apply strobe for the next edge
  task automatic cycle(string req, logic s);
    @(negedge clk);
    chk({req, " u0"}, pred_a, exp_bit(PAT_A, ph_a));
    chk({req, " u1"}, pred_b, exp_bit(PAT_B, ph_b));
    strobe = s;
    @(posedge clk);
    #1;
    if (s) begin
      ph_a = next_ph(ph_a, LEN_A);
      ph_b = next_ph(ph_b, LEN_B);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    strobe = 1'b0;
    rst_n  = 1'b0;
    #2;
    ph_a = 0;
    ph_b = 0;
    chk("R1 in reset u0", pred_a, PAT_A[0]);
    chk("R1 in reset u1", pred_b, PAT_B[0]);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int unsigned wrong;
    int unsigned branches;
    void'($urandom(32'd20111220));
    strobe = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    do_reset();

    // R1: first element visible right after release
    cycle("R1", 1'b0);

    // R3: idle cycles leave the prediction alone
    for (int i = 0; i < 5; i++) cycle("R3", 1'b0);

    // R2: single steps with idle gaps
    for (int i = 0; i < 3; i++) begin
      cycle("R2", 1'b1);
      cycle("R3", 1'b0);
    end

    // R4: unbroken strobes crossing both wrap points
    for (int i = 0; i < 12; i++) cycle("R4", 1'b1);

    // R6 and R8: stream aligned to reset, every branch predicted right
    do_reset();
    branches = 0;
    wrong    = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pred_a !== exp_bit(PAT_A, i % LEN_A)) wrong++;
      chk("R6", pred_a, exp_bit(PAT_A, i % LEN_A));
      chk("R8", pred_b, exp_bit(PAT_B, i % LEN_B));
      strobe = 1'b1;
      @(posedge clk);
      #1;
      ph_a = next_ph(ph_a, LEN_A);
      ph_b = next_ph(ph_b, LEN_B);
      branches++;
    end
    n_chk++;
    if (wrong != 0) begin
      n_fail++;
      $display("FAIL R6: actual %0d wrong expected 0 wrong", wrong);
    end

    // R7: stream is the inverse of the sequence; nothing predicted right
    do_reset();
    branches = 0;
    wrong    = 0;
    for (int i = 0; i < 30; i++) begin
      logic s;
      s = ($urandom % 4) != 0;
      @(negedge clk);
      if (s) begin
        branches++;
        if (pred_a !== ~exp_bit(PAT_A, ph_a)) wrong++;
        if (pred_b !== ~exp_bit(PAT_B, ph_b)) wrong++;
      end
      strobe = s;
      @(posedge clk);
      #1;
      if (s) begin
        ph_a = next_ph(ph_a, LEN_A);
        ph_b = next_ph(ph_b, LEN_B);
      end
    end
    n_chk++;
    if (wrong != 2 * branches) begin
      n_fail++;
      $display("FAIL R7: actual %0d mispredicts expected %0d", wrong, 2 * branches);
    end

    // R5: random strobe density, output tracks strobe count modulo period
    for (int i = 0; i < 400; i++) begin
      int unsigned dens;
      dens = (i / 100) + 1;
      cycle("R5", ($urandom % 5) < dens);
    end

    // R1: reset in the middle of a sequence restarts at element 0
    cycle("R5", 1'b1);
    cycle("R5", 1'b1);
    do_reset();
    cycle("R1 mid-run", 1'b1);
    cycle("R2", 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule